// File: doc/BRIEF.md
# Read-Valid Rate Crossing

This block moves read-completion events from a fast memory-side clock into a slow user-side clock that runs at exactly half the fast frequency, with rising edges aligned. The fast side reports each returned read by flipping a level (the toggle) and at the same time presents the read data and a destination tag naming the port that asked for it. Because one slow period spans two fast periods, the toggle can flip in either half of a slow period. A run of reads with uneven pacing or odd burst lengths can also put an odd number of fast cycles between two flips.

Every flip is captured in the fast domain together with its data and tag. It goes into a small holding queue indexed by a fast-side write pointer. The slow domain drains the queue with its own read pointer, one event per slow cycle at most, and presents each event as a single-cycle valid with its data and tag. A parameter selects a same-rate variant instead. In that variant both ports are driven by one clock, the queue is omitted, and an event is delivered on the next clock.

Top module: `rdv_rate_bridge`

## Requirements
- R1: Each change of level on `rd_toggle` is one event. Its `rd_data` and `rd_tag` are taken at the first `src_clk` rising edge that sees the change. Every event that is not dropped under R4 appears on the outputs exactly once, with its own data and tag, in the order of the toggle changes, including changes on consecutive `src_clk` cycles.
- R2: In the default mode, consider an isolated event. Its `out_valid` rises at the first `dst_clk` rising edge strictly after the `src_clk` edge that captured it, and stays high for one `dst_clk` cycle. This holds whether the capturing edge coincides with a `dst_clk` rising edge or falls between two of them.
- R3: At most one event is delivered per `dst_clk` cycle. Events that arrive faster wait in the queue and are delivered on consecutive `dst_clk` cycles with no idle cycle between them while any are pending.
- R4: The queue holds DEPTH (default 4) events. The pending count is the write pointer minus the read pointer as they stand before the capturing edge. An event that finds DEPTH pending is discarded and sets `overflow`, which stays set until reset. With the defaults, seven changes on consecutive `src_clk` cycles overflow on the seventh if the first is captured on an edge shared with `dst_clk`, and do not overflow otherwise. Six never overflow.
- R5: `rst` is active high and synchronous in both domains. It clears both pointers, `out_valid`, `out_data`, `out_tag` and `overflow`. While `rst` is high, the stored toggle copy follows `rd_toggle`, so a level held through reset yields no event.
- R6: While `out_valid` is low, `out_data` and `out_tag` hold their last delivered values.
- R7: With MODE set to the same-rate variant, both clocks are one clock. A toggle change seen at a rising edge gives `out_valid` high with that event's data and tag for the following cycle only, and `overflow` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast (half-rate) clock |
| dst_clk | input | 1 | Slow (quarter-rate) clock, rising edges aligned with src_clk |
| rst | input | 1 | Active-high synchronous reset, both domains |
| rd_toggle | input | 1 | Flips once per returned read |
| rd_data | input | DATA_W | Read data presented with the flip |
| rd_tag | input | TAG_W | Destination tag presented with the flip |
| out_valid | output | 1 | One-cycle event strobe in the slow domain |
| out_data | output | DATA_W | Data of the delivered event |
| out_tag | output | TAG_W | Tag of the delivered event |
| overflow | output | 1 | Sticky: an event was dropped with the queue full |

## Verification
The two functions that can meet on one edge are the fast-side capture of a new event and the slow-side drain of an older one. They coincide on every fast edge shared with a slow edge, and the drain must then use the write pointer as it stood before that edge. The bench provokes this by choosing the slow-clock phase before each burst. It sweeps gaps of one to five fast cycles and bursts of one to six events in both phases. It also sends seven back-to-back events in each phase, expecting an overflow in one phase and none in the other. Each delivery is judged against an arithmetic scoreboard for data, tag and order, and isolated events are also checked for their exact delivery edge.

// File: rtl/rdvx_pkg.sv
package rdvx_pkg;

    typedef enum logic {
        RDVX_HALF_TO_QUARTER = 1'b0,
        RDVX_SAME_RATE       = 1'b1
    } rdvx_mode_e;

endpackage

// File: rtl/rdvx_toggle_detect.sv
module rdvx_toggle_detect (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic evt
);

    typedef struct packed {
        logic tog;
    } state_t;

    state_t st_d, st_q;

    // The copy always follows the input; under reset no event is reported.
    always_comb begin
        st_d     = st_q;
        st_d.tog = tog_in;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign evt = !rst && (tog_in != st_q.tog);

endmodule

// File: rtl/rdvx_hold_queue.sv
module rdvx_hold_queue #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              overflow
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    typedef struct packed {
        logic [PTR_W-1:0]    wr;
        logic                ovf;
        entry_t [DEPTH-1:0]  mem;
    } state_t;

    state_t           st_d, st_q;
    logic [PTR_W-1:0] fill;

    always_comb begin
        st_d = st_q;
        fill = st_q.wr - rd_ptr;
        if (wr_en) begin
            if (fill == PTR_W'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.mem[st_q.wr[IDX_W-1:0]].data = wr_data;
                st_d.mem[st_q.wr[IDX_W-1:0]].tag  = wr_tag;
                st_d.wr                           = st_q.wr + PTR_W'(1);
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_ptr   = st_q.wr;
    assign rd_data  = st_q.mem[rd_ptr[IDX_W-1:0]].data;
    assign rd_tag   = st_q.mem[rd_ptr[IDX_W-1:0]].tag;
    assign overflow = st_q.ovf;

endmodule

// File: rtl/rdvx_drain.sv
module rdvx_drain #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);

    typedef struct packed {
        logic [PTR_W-1:0]  rd;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (wr_ptr != st_q.rd) begin
            st_d.vld  = 1'b1;
            st_d.data = rd_data;
            st_d.tag  = rd_tag;
            st_d.rd   = st_q.rd + PTR_W'(1);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_ptr    = st_q.rd;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_tag   = st_q.tag;

endmodule

// File: rtl/rdvx_direct_stage.sv
module rdvx_direct_stage #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = evt;
        if (evt) begin
            st_d.data = in_data;
            st_d.tag  = in_tag;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_tag   = st_q.tag;

endmodule

// File: rtl/rdv_rate_bridge.sv
module rdv_rate_bridge #(
    parameter int                   DATA_W = 16,
    parameter int                   TAG_W  = 4,
    parameter int                   DEPTH  = 4,
    parameter rdvx_pkg::rdvx_mode_e MODE   = rdvx_pkg::RDVX_HALF_TO_QUARTER
) (
    input  logic              src_clk,
    input  logic              dst_clk,
    input  logic              rst,
    input  logic              rd_toggle,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag,
    output logic              overflow
);

    localparam int PTR_W = $clog2(DEPTH) + 1;

    logic evt;

    rdvx_toggle_detect u_detect (
        .clk    (src_clk),
        .rst    (rst),
        .tog_in (rd_toggle),
        .evt    (evt)
    );

    generate
        if (MODE == rdvx_pkg::RDVX_SAME_RATE) begin : g_same
            rdvx_direct_stage #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W)
            ) u_direct (
                .clk       (dst_clk),
                .rst       (rst),
                .evt       (evt),
                .in_data   (rd_data),
                .in_tag    (rd_tag),
                .out_valid (out_valid),
                .out_data  (out_data),
                .out_tag   (out_tag)
            );
            assign overflow = 1'b0;
        end else begin : g_quarter
            logic [PTR_W-1:0]  wr_ptr;
            logic [PTR_W-1:0]  rd_ptr;
            logic [DATA_W-1:0] head_data;
            logic [TAG_W-1:0]  head_tag;

            rdvx_hold_queue #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W),
                .DEPTH  (DEPTH)
            ) u_queue (
                .clk      (src_clk),
                .rst      (rst),
                .wr_en    (evt),
                .wr_data  (rd_data),
                .wr_tag   (rd_tag),
                .rd_ptr   (rd_ptr),
                .wr_ptr   (wr_ptr),
                .rd_data  (head_data),
                .rd_tag   (head_tag),
                .overflow (overflow)
            );

            rdvx_drain #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W),
                .PTR_W  (PTR_W)
            ) u_drain (
                .clk       (dst_clk),
                .rst       (rst),
                .wr_ptr    (wr_ptr),
                .rd_data   (head_data),
                .rd_tag    (head_tag),
                .rd_ptr    (rd_ptr),
                .out_valid (out_valid),
                .out_data  (out_data),
                .out_tag   (out_tag)
            );
        end
    endgenerate

endmodule

// File: rtl/rdvx_checker.sv
module rdvx_checker #(
    parameter int                   DATA_W = 16,
    parameter int                   TAG_W  = 4,
    parameter rdvx_pkg::rdvx_mode_e MODE   = rdvx_pkg::RDVX_HALF_TO_QUARTER
) (
    input logic              src_clk,
    input logic              dst_clk,
    input logic              rst,
    input logic              rd_toggle,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [TAG_W-1:0]  out_tag,
    input logic              overflow
);

    int unsigned n_in;
    int unsigned n_out;
    logic        tog_prev;

    always_ff @(posedge src_clk) begin
        tog_prev <= rd_toggle;
        if (rst) begin
            n_in <= 0;
        end else if (rd_toggle != tog_prev) begin
            n_in <= n_in + 1;
        end
    end

    always_ff @(posedge dst_clk) begin
        if (rst) begin
            n_out <= 0;
        end else if (out_valid) begin
            n_out <= n_out + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge dst_clk) rst |=> !out_valid); // R5

    AST_HOLD_IDLE: assert property (@(posedge dst_clk) disable iff (rst)
        !out_valid |-> ($stable(out_data) && $stable(out_tag))); // R6

    generate
        if (MODE == rdvx_pkg::RDVX_SAME_RATE) begin : g_same_chk
            AST_NEXT_CLOCK: assert property (@(posedge dst_clk) disable iff (rst)
                (rd_toggle != $past(rd_toggle)) |=> out_valid); // R7
        end else begin : g_quarter_chk
            AST_NO_SPURIOUS: assert property (@(posedge dst_clk) disable iff (rst)
                out_valid |-> (n_out < n_in)); // R1
            AST_OVF_STICKY: assert property (@(posedge src_clk) disable iff (rst)
                overflow |=> overflow); // R4
            AST_OVF_CLEARED: assert property (@(posedge src_clk)
                rst |=> !overflow); // R5
        end
    endgenerate

endmodule

bind rdv_rate_bridge rdvx_checker #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .MODE   (MODE)
) u_rdvx_checker (
    .src_clk   (src_clk),
    .dst_clk   (dst_clk),
    .rst       (rst),
    .rd_toggle (rd_toggle),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .overflow  (overflow)
);

// File: tb/rdv_rate_bridge_bench.sv
module rdv_rate_bridge_bench;

    localparam int DW = 16;
    localparam int TW = 4;

    logic          clk_src = 1'b0;
    logic          clk_dst = 1'b0;
    logic          rst     = 1'b1;
    logic          tog     = 1'b0;
    logic [DW-1:0] din     = '0;
    logic [TW-1:0] tin     = '0;

    logic          q_valid, q_ovf, s_valid, s_ovf;
    logic [DW-1:0] q_data, s_data;
    logic [TW-1:0] q_tag, s_tag;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    // Scoreboards: arithmetic expected values pushed when an event is driven.
    logic [DW-1:0] qx_d [0:1023];
    logic [TW-1:0] qx_t [0:1023];
    logic [DW-1:0] sx_d [0:1023];
    logic [TW-1:0] sx_t [0:1023];
    int qx_head = 0, qx_tail = 0, sx_head = 0, sx_tail = 0;
    int ev_id = 0;
    int scyc = 0;
    int fired_at = -10;
    int q_run = 0, q_run_max = 0, q_seen = 0;
    logic [DW-1:0] last_d = '0;
    logic [TW-1:0] last_t = '0;

    rdv_rate_bridge #(.DATA_W(DW), .TAG_W(TW), .DEPTH(4),
                      .MODE(rdvx_pkg::RDVX_HALF_TO_QUARTER)) u_rdv_rate_bridge (
        .src_clk(clk_src), .dst_clk(clk_dst), .rst(rst), .rd_toggle(tog),
        .rd_data(din), .rd_tag(tin), .out_valid(q_valid), .out_data(q_data),
        .out_tag(q_tag), .overflow(q_ovf));

    rdv_rate_bridge #(.DATA_W(DW), .TAG_W(TW), .DEPTH(4),
                      .MODE(rdvx_pkg::RDVX_SAME_RATE)) u_rdv_rate_bridge_same (
        .src_clk(clk_src), .dst_clk(clk_src), .rst(rst), .rd_toggle(tog),
        .rd_data(din), .rd_tag(tin), .out_valid(s_valid), .out_data(s_data),
        .out_tag(s_tag), .overflow(s_ovf));

    // 100 MHz fast clock; slow clock at half rate with aligned rising edges.
    initial begin
        #5;
        forever begin
            clk_src = 1'b1; #5;
            clk_src = 1'b0; #5;
        end
    end
    initial begin
        #5;
        forever begin
            clk_dst = 1'b1; #10;
            clk_dst = 1'b0; #10;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    // Drive one event in the current time step (called just after a fast falling edge).
    task automatic fire_now(input bit to_q);
        tog = ~tog;
        din = DW'(ev_id * 173 + 41);
        tin = TW'(ev_id * 5 + 3);
        sx_d[sx_tail % 1024] = din;
        sx_t[sx_tail % 1024] = tin;
        sx_tail++;
        if (to_q) begin
            qx_d[qx_tail % 1024] = din;
            qx_t[qx_tail % 1024] = tin;
            qx_tail++;
        end
        fired_at = scyc;
        ev_id++;
    endtask

    task automatic fire(input bit to_q);
        @(negedge clk_src);
        fire_now(to_q);
    endtask

    // coincident=1: the next fast rising edge is also a slow rising edge.
    task automatic pick_phase(input bit coincident);
        forever begin
            @(negedge clk_src);
            if (clk_dst == !coincident) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk_src);
        rst = 1'b1;
        repeat (4) @(negedge clk_dst);
        @(negedge clk_src);
        qx_head = qx_tail;
        sx_head = sx_tail;
        rst = 1'b0;
    endtask

    // Slow-domain monitor, sampled just after each slow rising edge.
    always @(posedge clk_dst) begin
        #2;
        if (rst) begin
            last_d = '0;
            last_t = '0;
            q_run  = 0;
        end else if (q_valid) begin
            q_seen++;
            q_run++;
            if (q_run > q_run_max) q_run_max = q_run;
            if (qx_head == qx_tail) begin
                check(1'b0, "R1 unexpected delivery", 32'(q_data), 32'hffffffff);
            end else begin
                check(q_data == qx_d[qx_head % 1024], "R1 data", 32'(q_data),
                      32'(qx_d[qx_head % 1024]));
                check(q_tag == qx_t[qx_head % 1024], "R1 tag", 32'(q_tag),
                      32'(qx_t[qx_head % 1024]));
                qx_head++;
            end
            last_d = q_data;
            last_t = q_tag;
        end else begin
            q_run = 0;
            check(q_data == last_d && q_tag == last_t, "R6 hold",
                  {q_data, 12'h0, q_tag}, {last_d, 12'h0, last_t});
        end
    end

    // Same-rate monitor, sampled just after each fast rising edge.
    always @(posedge clk_src) begin
        scyc++;
        #2;
        if (!rst) begin
            if (s_valid || (fired_at == scyc - 1)) begin
                check(s_valid == (fired_at == scyc - 1), "R7 next-clock valid",
                      32'(s_valid), 32'(fired_at == scyc - 1));
            end
            if (s_valid && sx_head != sx_tail) begin
                check(s_data == sx_d[sx_head % 1024] && s_tag == sx_t[sx_head % 1024],
                      "R7 data/tag", {s_data, 12'h0, s_tag},
                      {sx_d[sx_head % 1024], 12'h0, sx_t[sx_head % 1024]});
                sx_head++;
            end
            check(s_ovf == 1'b0, "R7 no overflow", 32'(s_ovf), 32'h0);
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R5: level change during reset and held level afterwards give no event.
        repeat (2) @(negedge clk_src);
        tog = 1'b1;
        repeat (4) @(negedge clk_dst);
        @(negedge clk_src);
        rst = 1'b0;
        #1;
        check(q_valid == 1'b0 && q_ovf == 1'b0, "R5 outputs low after reset",
              {q_valid, q_ovf}, 32'h0);
        check(q_data == '0 && q_tag == '0, "R5 data/tag cleared", {q_data, 12'h0, q_tag}, 32'h0);
        check(s_valid == 1'b0, "R5 same-rate valid low", 32'(s_valid), 32'h0);
        q_seen = 0;
        repeat (10) @(posedge clk_dst);
        #3;
        check(q_seen == 0, "R5 no event from held level", q_seen, 32'h0);

        // R2: isolated event latency in both phases.
        for (int ph = 0; ph < 2; ph++) begin
            int first;
            first = 0;
            pick_phase(ph[0]);
            fire_now(1'b1);
            for (int k = 1; k <= 3; k++) begin
                @(posedge clk_dst);
                #3;
                if (q_valid && first == 0) first = k;
            end
            check(first == (ph == 1 ? 2 : 1), "R2 delivery edge", first, (ph == 1) ? 2 : 1);
            check(q_valid == 1'b0, "R2 single-cycle valid", 32'(q_valid), 32'h0);
        end

        // R1/R3: sweep gaps, phases and burst lengths.
        for (int gap = 1; gap <= 5; gap++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int len = 1; len <= 6; len++) begin
                    q_run_max = 0;
                    pick_phase(ph[0]);
                    fire_now(1'b1);
                    for (int i = 1; i < len; i++) begin
                        repeat (gap - 1) @(negedge clk_src);
                        fire(1'b1);
                    end
                    repeat (24) @(posedge clk_dst);
                    #3;
                    check(qx_head == qx_tail, "R1 all delivered", qx_tail - qx_head, 32'h0);
                    if (gap == 1) begin
                        check(q_run_max == len, "R3 consecutive delivery", q_run_max, len);
                    end
                end
            end
        end
        check(q_ovf == 1'b0, "R4 no overflow in sweep", 32'(q_ovf), 32'h0);

        // R4: seven back-to-back, first captured on a shared edge: seventh dropped.
        do_reset();
        pick_phase(1'b1);
        fire_now(1'b1);
        for (int i = 1; i < 7; i++) fire(i < 6);
        repeat (24) @(posedge clk_dst);
        #3;
        check(q_ovf == 1'b1, "R4 overflow on seventh", 32'(q_ovf), 32'h1);
        check(qx_head == qx_tail, "R4 six delivered", qx_tail - qx_head, 32'h0);
        repeat (4) @(posedge clk_dst);
        #3;
        check(q_ovf == 1'b1, "R4 overflow sticky", 32'(q_ovf), 32'h1);

        // R5: reset clears overflow.
        do_reset();
        #1;
        check(q_ovf == 1'b0, "R5 overflow cleared", 32'(q_ovf), 32'h0);

        // R4: seven back-to-back in the other phase: no overflow.
        q_run_max = 0;
        pick_phase(1'b0);
        fire_now(1'b1);
        for (int i = 1; i < 7; i++) fire(1'b1);
        repeat (24) @(posedge clk_dst);
        #3;
        check(q_ovf == 1'b0, "R4 seven fit in this phase", 32'(q_ovf), 32'h0);
        check(qx_head == qx_tail, "R1 seven delivered", qx_tail - qx_head, 32'h0);
        check(q_run_max == 7, "R3 seven consecutive", q_run_max, 32'd7);
        check(sx_head == sx_tail, "R7 all same-rate delivered", sx_tail - sx_head, 32'h0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule